// File: doc/BRIEF.md
# Externally clocked synchronous serial transmitter

This block is the transmit half of a synchronous serial port that runs as a slave. The far end supplies the shift clock on an input pin. The block moves data words out on a single data pin, one bit per clock, least-significant bit first. The data pin changes after each falling edge of the external clock, so the far end can sample it on the rising edge. The external clock is brought into the local clock domain through a synchroniser chain and an edge detector.

Software writes words into a holding register. When the shift register is idle, a word moves from the holding register into it straight away. While a word is being shifted, a second word can wait in the holding register. The transmit flag reads 1 whenever the holding register is empty. It therefore stays low while a queued word waits, and rises only when that word moves into the shifter. An optional ninth bit is taken from the control register when a word is loaded. The interrupt request is a purely combinational AND of the flag and its enable, so it still works when the local clock is stopped and can serve as a wake-up.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x02 (only the shift-empty bit is set), `txf` is 1, `tx_pin` is 1 and `irq` is 0.
- R2: Control register layout, from bit 7 down to bit 0: clock-source select (0 = external clock, slave), nine-bit enable, transmit enable, synchronous mode, break request, high-speed select, shift-empty status, ninth data bit. Bits 7, 6, 5, 4, 3, 2 and 0 read back what was written. Bit 1 is read-only: it reads 1 when the shifter holds no bits still to send, and a write to it has no effect.
- R3: A write to the holding register makes `txf` read 0 after the next clock edge. If the port is active and the shifter is empty, the word moves into the shifter on the following edge: `txf` returns to 1 and the shift-empty bit goes to 0.
- R4: A word written while the shifter is busy stays in the holding register and `txf` stays 0. When the last bit of the current word completes, the queued word loads into the shifter, and only then does `txf` become 1.
- R5: Within four local clock cycles of each falling edge of `ext_sck`, `tx_pin` shows the next bit of the word, least-significant bit first. A word completes at the rising edge that follows its last bit, and the shift-empty bit returns to 1 within four cycles of that edge if no word is queued.
- R6: When nine-bit enable (bit 6) is set at load time, the frame has 9 bits, and the ninth bit is the value of bit 0 of the control register at load time. Otherwise the frame has 8 bits.
- R7: The port is active only when transmit enable and synchronous mode are 1, clock-source select is 0, `port_en` is 1 and both `rx_single_en` and `rx_cont_en` are 0. While it is inactive, `tx_pin` is 1, the shift-empty bit is 1, and a word written to the holding register stays there with `txf` at 0 until the port becomes active.
- R8: `irq` equals `txf AND irq_en` combinationally, with no local clock edge needed.
- R9: A queued word follows the previous word with no idle bit. A falling edge of `ext_sck` with no word loaded drives `tx_pin` to 1.
- R10: Clearing transmit enable in the middle of a word abandons that word. Within two cycles `tx_pin` is 1 and the shift-empty bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_sck | input | 1 | Shift clock from the external master |
| tx_pin | output | 1 | Serial data out, idle high |
| port_en | input | 1 | Serial port enable |
| rx_single_en | input | 1 | Single-receive enable (must be 0 to transmit) |
| rx_cont_en | input | 1 | Continuous-receive enable (must be 0 to transmit) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value, with live shift-empty bit |
| hold_we | input | 1 | Holding register write strobe |
| hold_wdata | input | DATA_W | Holding register write data |
| txf | output | 1 | Transmit flag: holding register empty |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. With these values both frame lengths, 8 and 9 bits, are exercised through the ninth-bit field at full bit-counter range. The synchroniser latency is short enough that a slow external clock of five local cycles per phase covers every pin update with margin. Random bytes, random frame lengths and random ninth bits are mixed with directed cases: queueing behind a busy shifter, gating by each enable condition, aborting mid-word and idle edges after a frame.

// File: rtl/sst_pkg.sv
// Package: shared field positions and the control register type for the
// synchronous slave transmitter. Assumes an 8-bit control register.
package sst_pkg;
    localparam int CTL_W     = 8;
    localparam int F_CLKSRC  = 7;
    localparam int F_NINE    = 6;
    localparam int F_TXEN    = 5;
    localparam int F_SYNC    = 4;
    localparam int F_BRK     = 3;
    localparam int F_HS      = 2;
    localparam int F_EMPTY   = 1;
    localparam int F_D9      = 0;

    typedef struct packed {
        logic clk_src;
        logic nine_en;
        logic tx_en;
        logic sync_mode;
        logic brk;
        logic hs;
        logic d9;
    } ctl_t;
endpackage

// File: rtl/sst_edge_sync.sv
// Module: brings an asynchronous clock input into the local domain through
// STAGES flops and reports single-cycle rise and fall pulses.
// Assumes the input phase lasts longer than STAGES+1 local cycles.
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Holds the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sst_ctl_reg.sv
// Module: control/status register. Stores the writable fields and forms
// the read value with the live shift-empty status inserted at its bit.
module sst_ctl_reg
    import sst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             shift_empty,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rdata
);
    // Captures writable fields; the status bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl.clk_src   <= wdata[F_CLKSRC];
            ctl.nine_en   <= wdata[F_NINE];
            ctl.tx_en     <= wdata[F_TXEN];
            ctl.sync_mode <= wdata[F_SYNC];
            ctl.brk       <= wdata[F_BRK];
            ctl.hs        <= wdata[F_HS];
            ctl.d9        <= wdata[F_D9];
        end
    end

    // Assembles the read image.
    always_comb begin
        rdata           = '0;
        rdata[F_CLKSRC] = ctl.clk_src;
        rdata[F_NINE]   = ctl.nine_en;
        rdata[F_TXEN]   = ctl.tx_en;
        rdata[F_SYNC]   = ctl.sync_mode;
        rdata[F_BRK]    = ctl.brk;
        rdata[F_HS]     = ctl.hs;
        rdata[F_EMPTY]  = shift_empty;
        rdata[F_D9]     = ctl.d9;
    end
endmodule

// File: rtl/sst_holding.sv
// Module: holding register with its full flag. A write fills it; a load
// into the shifter empties it. A write in the same cycle as a load wins,
// so the register stays full with the new word.
module sst_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic [DATA_W-1:0] word,
    output logic              full
);
    // Tracks occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)    full <= 1'b0;
        else if (we)   full <= 1'b1;
        else if (load) full <= 1'b0;
    end

    // Stores the written word.
    always_ff @(posedge clk) begin
        if (!rst_n)  word <= '0;
        else if (we) word <= wdata;
    end
endmodule

// File: rtl/sst_shifter.sv
// Module: shift register driven by synchronised external clock edges.
// The pin takes the next bit, LSB first, on each fall. The word completes
// on the rise after its last bit. Assumes rise and fall never coincide.
module sst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              nine_en,
    input  logic              d9,
    input  logic              fall,
    input  logic              rise,
    output logic              busy,
    output logic              pin
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] LEN8 = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN9 = CNT_W'(SH_W);

    logic [SH_W-1:0]  sh,  sh_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] len, len_n;
    logic             busy_n, pin_n;

    // Next-state logic for load, shift, completion and abort.
    always_comb begin
        sh_n   = sh;
        cnt_n  = cnt;
        len_n  = len;
        busy_n = busy;
        pin_n  = pin;
        if (!active) begin
            sh_n   = '0;
            cnt_n  = '0;
            busy_n = 1'b0;
            pin_n  = 1'b1;
        end else begin
            if (load) begin
                sh_n   = {d9, word};
                len_n  = nine_en ? LEN9 : LEN8;
                cnt_n  = '0;
                busy_n = 1'b1;
            end
            if (busy_n && fall) begin
                if (cnt_n < len_n) begin
                    pin_n = sh_n[0];
                    sh_n  = sh_n >> 1;
                    cnt_n = cnt_n + 1'b1;
                end
            end else if (!busy_n && fall) begin
                pin_n = 1'b1;
            end
            if (busy && !load && rise && (cnt == len)) begin
                busy_n = 1'b0;
            end
        end
    end

    // Registers the shifter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            len  <= LEN8;
            busy <= 1'b0;
            pin  <= 1'b1;
        end else begin
            sh   <= sh_n;
            cnt  <= cnt_n;
            len  <= len_n;
            busy <= busy_n;
            pin  <= pin_n;
        end
    end
endmodule

// File: rtl/sync_slave_tx.sv
// Module: top of the externally clocked synchronous transmitter. It joins
// the control register, holding register, clock synchroniser and shifter.
// The interrupt request is combinational so it works with clk stopped.
module sync_slave_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sck,
    output logic              tx_pin,
    input  logic              port_en,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              hold_we,
    input  logic [DATA_W-1:0] hold_wdata,
    output logic              txf,
    input  logic              irq_en,
    output logic              irq
);
    ctl_t              ctl;
    logic              busy, active, load, hold_full, rise, fall;
    logic [DATA_W-1:0] hold_word;

    sst_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .shift_empty(~busy), .ctl(ctl), .rdata(ctl_rdata)
    );

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_sck), .rise(rise), .fall(fall)
    );

    sst_holding #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .we(hold_we), .wdata(hold_wdata),
        .load(load), .word(hold_word), .full(hold_full)
    );

    // Port qualification and holding-to-shifter transfer decision.
    always_comb begin
        active = ctl.tx_en & ctl.sync_mode & ~ctl.clk_src
               & port_en & ~rx_single_en & ~rx_cont_en;
        load   = active & ~busy & hold_full;
    end

    sst_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .load(load),
        .word(hold_word), .nine_en(ctl.nine_en), .d9(ctl.d9),
        .fall(fall), .rise(rise), .busy(busy), .pin(tx_pin)
    );

    assign txf = ~hold_full;
    assign irq = txf & irq_en;
endmodule

// File: rtl/sst_checks.sv
// Checker: temporal properties of the transmitter, bound to the top.
module sst_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic       rx_single_en,
    input logic       rx_cont_en,
    input logic       hold_we,
    input logic       irq_en,
    input logic [7:0] ctl_rdata,
    input logic       txf,
    input logic       tx_pin,
    input logic       irq
);
    logic act_c;
    assign act_c = ~ctl_rdata[7] & ctl_rdata[5] & ctl_rdata[4]
                 & port_en & ~rx_single_en & ~rx_cont_en;

    a_r3_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hold_we |=> !txf);

    a_r4_flag_rises_only_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txf) |-> $past(ctl_rdata[1]));

    a_r7_inactive_idles_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !act_c |=> (tx_pin && ctl_rdata[1]));

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> txf);
endmodule

bind sync_slave_tx sst_checks u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_single_en(rx_single_en),
    .rx_cont_en(rx_cont_en), .hold_we(hold_we), .irq_en(irq_en),
    .ctl_rdata(ctl_rdata), .txf(txf), .tx_pin(tx_pin), .irq(irq)
);

// File: tb/sync_slave_tx_test.sv
module sync_slave_tx_test;
    logic       clk = 0, rst_n = 0, ext_sck = 1;
    logic       port_en = 0, rx_single_en = 0, rx_cont_en = 0;
    logic       ctl_we = 0, hold_we = 0, irq_en = 0;
    logic [7:0] ctl_wdata = 0, hold_wdata = 0, ctl_rdata;
    logic       tx_pin, txf, irq;
    int         tests = 0, fails = 0;

    always #5 clk = ~clk;

    sync_slave_tx uut (
        .clk(clk), .rst_n(rst_n), .ext_sck(ext_sck), .tx_pin(tx_pin),
        .port_en(port_en), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .hold_we(hold_we), .hold_wdata(hold_wdata), .txf(txf),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] w, input logic d9, input int i);
        return (i < 8) ? w[i] : d9;
    endfunction

    function automatic logic [7:0] ctl_val(input logic nine, input logic d9);
        return {1'b0, nine, 1'b1, 1'b1, 2'b00, 1'b0, d9};
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1; ctl_wdata = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic wr_hold(input logic [7:0] v);
        @(negedge clk); hold_we = 1; hold_wdata = v;
        @(negedge clk); hold_we = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One external clock period; the bit seen after the fall is returned.
    task automatic sck_cycle(output logic b);
        ext_sck = 0; wait_n(5);
        b = tx_pin;
        ext_sck = 1; wait_n(5);
    endtask

    task automatic check_frame(input string req, input logic [7:0] w,
                               input logic d9, input int n);
        logic b;
        for (int i = 0; i < n; i++) begin
            sck_cycle(b);
            chk(req, {15'd0, b}, {15'd0, exp_bit(w, d9, i)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic b;
        void'($urandom(32'd20240611));
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        chk("R1 ctl", {8'd0, ctl_rdata}, 16'h0002);
        chk("R1 txf", {15'd0, txf}, 16'd1);
        chk("R1 pin", {15'd0, tx_pin}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2 field readback, status bit read-only
        wr_ctl(8'hDD);
        chk("R2 readback", {8'd0, ctl_rdata}, 16'h00DF);
        wr_ctl(8'h00);
        chk("R2 empty bit ro", {8'd0, ctl_rdata}, 16'h0002);

        // R8 combinational irq
        irq_en = 1; #1;
        chk("R8 irq on", {15'd0, irq}, 16'd1);
        irq_en = 0; #1;
        chk("R8 irq off", {15'd0, irq}, 16'd0);

        // R7 inactive: word waits, pin idle
        port_en = 0;
        wr_ctl(ctl_val(0, 0));
        @(negedge clk); hold_we = 1; hold_wdata = 8'hA5;
        @(negedge clk); hold_we = 0;
        chk("R3 flag clears", {15'd0, txf}, 16'd0);
        wait_n(3);
        chk("R7 waits txf", {15'd0, txf}, 16'd0);
        chk("R7 empty", {15'd0, ctl_rdata[1]}, 16'd1);
        sck_cycle(b);
        chk("R7 pin idle", {15'd0, b}, 16'd1);
        rx_cont_en = 1; port_en = 1; wait_n(3);
        chk("R7 rx blocks", {15'd0, txf}, 16'd0);
        rx_cont_en = 0; wait_n(2);
        chk("R3 loaded txf", {15'd0, txf}, 16'd1);
        chk("R3 loaded busy", {15'd0, ctl_rdata[1]}, 16'd0);
        check_frame("R5 lsb first", 8'hA5, 0, 8);
        chk("R5 done", {15'd0, ctl_rdata[1]}, 16'd1);
        sck_cycle(b);
        chk("R9 idle high", {15'd0, b}, 16'd1);

        // R4 queued word, R9 no gap, R6 ninth bit
        wr_ctl(ctl_val(1, 1));
        wr_hold(8'h3C);
        wait_n(1);
        wr_hold(8'hC3);
        chk("R4 queued txf", {15'd0, txf}, 16'd0);
        for (int i = 0; i < 9; i++) begin
            ext_sck = 0; wait_n(5);
            chk("R6 first frame", {15'd0, tx_pin}, {15'd0, exp_bit(8'h3C, 1, i)});
            if (i == 8) chk("R4 still clear", {15'd0, txf}, 16'd0);
            ext_sck = 1; wait_n(5);
        end
        chk("R4 flag after move", {15'd0, txf}, 16'd1);
        chk("R4 second loaded", {15'd0, ctl_rdata[1]}, 16'd0);
        check_frame("R9 back to back", 8'hC3, 1, 9);
        chk("R6 done", {15'd0, ctl_rdata[1]}, 16'd1);

        // R10 abort mid-word
        wr_ctl(ctl_val(0, 0));
        wr_hold(8'h00);
        wait_n(1);
        check_frame("R10 pre", 8'h00, 0, 3);
        @(negedge clk); ctl_we = 1; ctl_wdata = 8'h10;
        @(negedge clk); ctl_we = 0;
        @(negedge clk);
        chk("R10 pin", {15'd0, tx_pin}, 16'd1);
        chk("R10 empty", {15'd0, ctl_rdata[1]}, 16'd1);

        // Random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] w;
            logic nine, d9;
            w = 8'($urandom);
            nine = 1'($urandom);
            d9 = 1'($urandom);
            wr_ctl(ctl_val(nine, d9));
            wr_hold(w);
            wait_n(1);
            chk("R3 random load", {15'd0, ctl_rdata[1]}, 16'd0);
            check_frame("R6 random frame", w, d9, nine ? 9 : 8);
            chk("R5 random done", {15'd0, ctl_rdata[1]}, 16'd1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule